// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps six event counters for an Ethernet MAC. Three count transmit outcomes: good frames, good frames sent after exactly one collision, and good frames sent after several collisions. Three count receive outcomes: frames with a CRC error, frames with an alignment (dribble) error, and good unicast frames. The MAC drives a one-cycle pulse on the matching bit of `evt` for each event. Software reads a counter through a registered read port.

A small control word selects the counting policy. The counters can wrap or stop at their maximum. They can clear themselves when read. The whole bank can be frozen, or wiped by a self-clearing command. Each counter raises a status bit when its top bit first becomes set, which is half of its range. A mask register selects which status bits drive the single interrupt line.

The policy is held by a mode machine with three states. In `ST_RUN` the counters count. In `ST_HOLD` they are frozen. `ST_WIPE` is a single cycle in which everything is cleared. The transitions are:
- RUN→HOLD: a control write with freeze set.
- HOLD→RUN: a control write with freeze clear.
- any→WIPE: a control write with the wipe bit set.
- WIPE→RUN or WIPE→HOLD: the next cycle, chosen by the freeze bit written together with the wipe.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset every counter reads 0, `sts` is 0, `irq` is 0, all mask bits are 0 and all control bits are 0.
- R2: A pulse on `evt[i]` adds one to counter i. The index map is: 0 transmit good, 1 transmit after one collision, 2 transmit after several collisions, 3 receive CRC error, 4 receive alignment error, 5 receive good unicast. A read is requested with `rd_en` and `rd_sel` = i. `rd_data` shows, one cycle later, the counter value from before that clock edge.
- R3: Counters 1 and 2 advance only while `half_duplex` is 1. Their pulses are ignored while it is 0.
- R4: The control word is: bit 0 wipe, bit 1 stop-at-max, bit 2 freeze, bit 3 clear-on-read. With stop-at-max at 0, a counter at all ones wraps to 0. With it at 1, the counter stays at all ones.
- R5: `sts[i]` sets on the edge where the top bit of counter i changes from 0 to 1. It stays set until counter i is read or the bank is wiped.
- R6: A mask write loads `msk_wdata`. A mask bit of 1 stops the matching status bit from driving `irq`. `irq` is the OR of all unmasked status bits, covering both the transmit and receive groups.
- R7: While freeze is 1, counters and status bits keep their values. Events and the side effects of reads are ignored, and reads still return the held values.
- R8: With clear-on-read set, a read counter becomes 0. If an event for the same counter arrives on the read edge, the counter becomes 1.
- R9: Writing the wipe bit clears all counters and all status bits one cycle after the write. Events on that clearing edge are lost. The bit does not stay set, so later events count normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 6 | One-cycle event pulses, one per counter |
| half_duplex | input | 1 | Link is half duplex; enables the collision counters |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: clear-on-read, freeze, stop-at-max, wipe |
| msk_we | input | 1 | Mask write strobe |
| msk_wdata | input | 6 | Mask bits, 1 = masked |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | Counter index to read |
| rd_data | output | CW (32) | Registered read data |
| sts | output | 6 | Half-range status bits |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- A counter never moves by more than one step, except when it is cleared.
- A frozen counter stays stable.
- A saturated counter stays at its maximum.
- A status bit is set on every cycle in which its counter's top bit rises.
- The wipe state lasts one cycle and leaves every status bit clear.

Other behaviours need the bench's scenarios to show them:
- the exact read values after wrap and saturation;
- the gating of the collision counters by duplex mode;
- the mask's effect on the interrupt;
- the value 1 that results when an event and a clearing read land on the same edge.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int N_CNT = 6;

    // event / counter indices
    localparam int IX_TX_GOOD   = 0;
    localparam int IX_TX_ONECOL = 1;
    localparam int IX_TX_MULCOL = 2;
    localparam int IX_RX_CRC    = 3;
    localparam int IX_RX_ALIGN  = 4;
    localparam int IX_RX_UCAST  = 5;

    typedef struct packed {
        logic clr_on_rd;  // bit 3
        logic freeze;     // bit 2
        logic sat;        // bit 1
        logic wipe;       // bit 0
    } ctl_word_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_WIPE = 2'd2
    } mode_t;
endpackage

// File: rtl/stat_ctl_fsm.sv
module stat_ctl_fsm
    import stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [3:0] ctl_wdata,
    output logic       clr_all,
    output logic       hold,
    output logic       sat_on,
    output logic       cor_on
);
    ctl_word_t wr;
    mode_t     state, state_nxt;
    logic      frz_q, sat_q, cor_q;
    logic      frz_eff;

    assign wr      = ctl_word_t'(ctl_wdata);
    assign frz_eff = ctl_we ? wr.freeze : frz_q;

    // policy bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_q <= 1'b0;
            sat_q <= 1'b0;
            cor_q <= 1'b0;
        end else if (ctl_we) begin
            frz_q <= wr.freeze;
            sat_q <= wr.sat;
            cor_q <= wr.clr_on_rd;
        end
    end

    // next state
    always_comb begin
        if (ctl_we && wr.wipe)
            state_nxt = ST_WIPE;
        else if (frz_eff)
            state_nxt = ST_HOLD;
        else
            state_nxt = ST_RUN;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        clr_all = 1'b0;
        hold    = 1'b0;
        unique case (state)
            ST_RUN:  begin end
            ST_HOLD: hold    = 1'b1;
            ST_WIPE: clr_all = 1'b1;
            default: clr_all = 1'b1;
        endcase
    end

    assign sat_on = sat_q;
    assign cor_on = cor_q;

    // R9: wipe lasts a single cycle unless another wipe is written
    a_r9_wipe_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIPE && !ctl_we) |=> (state != ST_WIPE));
endmodule

// File: rtl/stat_cell.sv
module stat_cell #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          hold,
    input  logic          sat_on,
    input  logic          cor_on,
    input  logic          inc,
    input  logic          rd_hit,
    output logic [CW-1:0] val,
    output logic          half_flag
);
    localparam int            TOP  = CW - 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] val_q, base, nxt;
    logic          flag_q, flag_nxt;

    always_comb begin
        base = (rd_hit && cor_on) ? '0 : val_q;
        if (inc && !(sat_on && base == CMAX))
            nxt = base + 1'b1;
        else
            nxt = base;
        flag_nxt = (flag_q & ~rd_hit) | (~val_q[TOP] & nxt[TOP]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            val_q  <= '0;
            flag_q <= 1'b0;
        end else if (!hold) begin
            val_q  <= nxt;
            flag_q <= flag_nxt;
        end
    end

    assign val       = val_q;
    assign half_flag = flag_q;

    // R7: frozen counter does not move
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr_all) |=> $stable(val_q) && $stable(flag_q));
    // R2: at most one step per cycle when not cleared
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !hold && !(rd_hit && cor_on)) |=>
            (val_q == $past(val_q)) || (val_q == $past(val_q) + 1'b1));
    // R4: saturated counter stays at maximum
    a_r4_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_on && !clr_all && val_q == CMAX && !(rd_hit && cor_on)) |=> (val_q == CMAX));
    // R5: status is set whenever the top bit rises
    a_r5_flag_on_half: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(val_q[TOP]) |-> flag_q);
    // R8: a clearing read leaves at most one count
    a_r8_cor_small: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && cor_on && !hold && !clr_all) |=> (val_q <= 1));
endmodule

// File: rtl/stat_irq.sv
module stat_irq #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         msk_we,
    input  logic [N-1:0] msk_wdata,
    input  logic [N-1:0] sts,
    output logic         irq
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (msk_we) mask_q <= msk_wdata;
    end

    assign irq = |(sts & ~mask_q);

    // R6: no interrupt without a pending status bit
    a_r6_irq_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts != '0));
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
    import stat_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CNT-1:0] evt,
    input  logic             half_duplex,
    input  logic             ctl_we,
    input  logic [3:0]       ctl_wdata,
    input  logic             msk_we,
    input  logic [N_CNT-1:0] msk_wdata,
    input  logic             rd_en,
    input  logic [2:0]       rd_sel,
    output logic [CW-1:0]    rd_data,
    output logic [N_CNT-1:0] sts,
    output logic             irq
);
    logic          clr_all, hold, sat_on, cor_on;
    logic [CW-1:0] cnt [N_CNT];
    logic [CW-1:0] rd_mux;
    logic [CW-1:0] rd_q;

    stat_ctl_fsm u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .clr_all(clr_all), .hold(hold), .sat_on(sat_on), .cor_on(cor_on)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_cell
        logic inc_i;
        if (i == IX_TX_ONECOL || i == IX_TX_MULCOL) begin : g_hd
            assign inc_i = evt[i] & half_duplex;
        end else begin : g_any
            assign inc_i = evt[i];
        end
        stat_cell #(.CW(CW)) u_cell (
            .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .hold(hold),
            .sat_on(sat_on), .cor_on(cor_on), .inc(inc_i),
            .rd_hit(rd_en && (rd_sel == 3'(i))),
            .val(cnt[i]), .half_flag(sts[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < N_CNT; i++)
            if (rd_sel == 3'(i)) rd_mux = cnt[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
    end
    assign rd_data = rd_q;

    stat_irq #(.N(N_CNT)) u_irq (
        .clk(clk), .rst_n(rst_n), .msk_we(msk_we), .msk_wdata(msk_wdata),
        .sts(sts), .irq(irq)
    );

    // R9: after the clearing cycle no status bit remains
    a_r9_sts_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (sts == '0));
endmodule

// File: tb/stat_counter_bank_test.sv
module stat_counter_bank_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   evt = '0;
    logic         half_duplex = 1'b1;
    logic         ctl_we = 1'b0;
    logic [3:0]   ctl_wdata = '0;
    logic         msk_we = 1'b0;
    logic [5:0]   msk_wdata = '0;
    logic         rd_en = 1'b0;
    logic [2:0]   rd_sel = '0;
    logic [W-1:0] rd_data;
    logic [5:0]   sts;
    logic         irq;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    stat_counter_bank #(.CW(W)) uut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .half_duplex(half_duplex),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .msk_we(msk_we),
        .msk_wdata(msk_wdata), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .sts(sts), .irq(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic pulse(input logic [5:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt = v;
            @(negedge clk); evt = '0;
        end
    endtask

    task automatic rd(input int s, output int d);
        @(negedge clk); rd_en = 1'b1; rd_sel = 3'(s);
        @(negedge clk); rd_en = 1'b0;
        d = int'(rd_data);
    endtask

    task automatic wctl(input logic [3:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wmsk(input logic [5:0] v);
        @(negedge clk); msk_we = 1'b1; msk_wdata = v;
        @(negedge clk); msk_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 sts", int'(sts), 0);
        chk("R1 irq", int'(irq), 0);
        for (int i = 0; i < 6; i++) begin rd(i, d); chk("R1 count", d, 0); end

        // R2 each counter counts its own events
        for (int i = 0; i < 6; i++) pulse(6'(1 << i), i + 2);
        for (int i = 0; i < 6; i++) begin rd(i, d); chk("R2 count", d, i + 2); end

        // R3 duplex gating of collision counters
        wctl(4'b0001);
        half_duplex = 1'b0;
        pulse(6'b111111, 5);
        for (int i = 0; i < 6; i++) begin
            rd(i, d); chk("R3 full duplex", d, (i == 1 || i == 2) ? 0 : 5);
        end
        half_duplex = 1'b1;
        pulse(6'b111111, 2);
        for (int i = 0; i < 6; i++) begin
            rd(i, d); chk("R3 half duplex", d, (i == 1 || i == 2) ? 2 : 7);
        end

        // R5 half-range status, R4 wrap
        wctl(4'b0001);
        pulse(6'b000001, 127);
        chk("R5 below half sts", int'(sts[0]), 0);
        rd(0, d); chk("R5 count 127", d, 127);
        pulse(6'b000001, 1);
        chk("R5 at half sts", int'(sts[0]), 1);
        chk("R6 irq unmasked", int'(irq), 1);
        rd(0, d); chk("R5 count 128", d, 128);
        chk("R5 read clears sts", int'(sts[0]), 0);
        chk("R6 irq after read", int'(irq), 0);
        pulse(6'b000001, 128);
        rd(0, d); chk("R4 wrap to zero", d, 0);
        chk("R5 no re-raise on wrap", int'(sts[0]), 0);

        // R4 stop at max
        wctl(4'b0011);
        pulse(6'b001000, 300);
        chk("R5 sts during sat", int'(sts[3]), 1);
        rd(3, d); chk("R4 saturate", d, 255);

        // R6 mask
        wmsk(6'b001000);
        pulse(6'b010000, 128);
        chk("R6 sts4", int'(sts[4]), 1);
        chk("R6 irq other masked", int'(irq), 1);
        wmsk(6'b010000);
        chk("R6 irq masked", int'(irq), 0);
        chk("R6 sts kept", int'(sts[4]), 1);
        wmsk(6'b000000);
        chk("R6 irq unmasked again", int'(irq), 1);
        rd(4, d); chk("R6 count4", d, 128);

        // R7 freeze with clear-on-read programmed
        wctl(4'b0001);
        pulse(6'b000100, 7);
        wctl(4'b1100);
        pulse(6'b111111, 10);
        rd(2, d); chk("R7 frozen read", d, 7);
        rd(2, d); chk("R7 no clear while frozen", d, 7);
        rd(0, d); chk("R7 events ignored", d, 0);

        // R8 clear-on-read
        wctl(4'b1000);
        rd(2, d); chk("R8 read value", d, 7);
        rd(2, d); chk("R8 cleared", d, 0);
        pulse(6'b100000, 4);
        @(negedge clk); evt = 6'b100000; rd_en = 1'b1; rd_sel = 3'd5;
        @(negedge clk); evt = '0; rd_en = 1'b0;
        chk("R8 same-edge read value", int'(rd_data), 4);
        rd(5, d); chk("R8 event plus clear", d, 1);

        // R9 wipe
        wctl(4'b0000);
        pulse(6'b111111, 3);
        pulse(6'b010000, 130);
        chk("R9 sts before wipe", int'(sts[4]), 1);
        wctl(4'b0001);
        chk("R9 sts wiped", int'(sts), 0);
        for (int i = 0; i < 6; i++) begin rd(i, d); chk("R9 wiped", d, 0); end
        pulse(6'b000010, 2);
        rd(1, d); chk("R9 counts after wipe", d, 2);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule